// File: doc/BRIEF.md
# Periodic, Alarm and Power-Fail Interrupt Unit

This unit gathers three event sources into one active-low interrupt request. A programmable divider counts enable pulses from a 32.768 kHz timebase and raises a periodic event. An alarm comparator checks the seconds, minutes, hours and date fields of the current time against four alarm bytes on each once-per-second update strobe. An external power-fail event is the third source. Each source sets a sticky flag. A flag drives the interrupt line only when its own enable bit is set.

Software reaches the unit through a small synchronous register port. Four alarm bytes sit at addresses 0x1, 0x3, 0x5 and 0x7. The enable and rate register sits at 0xC, and the flags register at 0xD. Reading the flags register clears every flag, but only when the address was held on 0xD for a minimum number of clocks. A shorter read returns the flags and leaves them set. While the system runs from its backup supply, the interrupt line is released, except that an alarm can still wake the system when it has been armed to do so.

Top module: `tick_alarm_irq`

## Requirements
- R1: After reset, the enable register, the flags register and all four alarm bytes read 0, and `irq_n` is 1. With the enables still clear, an event only sets its flag and `irq_n` stays 1.
- R2: With rate code 0 in bits 3:0 of register 0xC, no number of timebase pulses ever sets the periodic flag.
- R3: For a rate code n from 1 to 15, the periodic flag is set on timebase pulse number 2^(n-1) after the last write to register 0xC, and again on every further 2^(n-1) pulses.
- R4: An alarm byte is masked when its bits 7:6 are both 1. An unmasked byte is compared over all 8 bits with its time field (0x1 with seconds, 0x3 with minutes, 0x5 with hours, 0x7 with date). The alarm flag is set only in a cycle with `upd_stb` high in which every unmasked byte matches.
- R5: When all bytes are masked, the alarm fires on every strobe. Comparing only seconds matches once per minute, adding minutes once per hour, adding hours once per day, and comparing all four matches on a date and time.
- R6: A high `pwr_fail_evt` sets the power-fail flag on the next clock edge.
- R7: Outside backup mode, `irq_n` is 0 exactly when a flag and its enable are both set. In register 0xC, bit 4 enables the periodic flag, bit 5 the alarm flag and bit 6 the power-fail flag.
- R8: All flags clear together on the first clock edge after a read of 0xD ends, provided that the read lasted at least HOLD_CYC clock edges. A shorter read returns the flags and clears nothing.
- R9: A flag whose event arrives on the same edge as a clear stays set, while the other flags clear.
- R10: With `backup_mode` high, `irq_n` is 1 unless bit 7 of 0xC (alarm wake in backup) and bit 5 are both set and the alarm flag is set. In that case `irq_n` is 0.
- R11: Register 0xD reads the power-fail flag in bit 0, the periodic flag in bit 1 and the alarm flag in bit 2, with the upper bits 0. Writes to 0xD are ignored. Unused addresses read 0, and register 0xC reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick32k_en | input | 1 | One-cycle pulse per 32.768 kHz timebase period |
| upd_stb | input | 1 | One-cycle strobe marking a time-field update |
| sec_bcd | input | 8 | Current seconds, BCD |
| min_bcd | input | 8 | Current minutes, BCD |
| hr_bcd | input | 8 | Current hours, BCD (bit 7 may carry PM) |
| date_bcd | input | 8 | Current day of month, BCD |
| pwr_fail_evt | input | 1 | Power-fail detection event |
| backup_mode | input | 1 | High while running from the backup supply |
| bus_sel | input | 1 | Register access active this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `pwr_fail_evt`, `upd_stb` and `tick32k_en` are synchronous to `clk`. They also assume that a register access keeps its address and direction stable while `bus_sel` is high, since the hold counter treats any change as the end of a read. The bench drives every input at the falling edge. It changes the bus only between whole accesses, and it never pulses the timebase in the same cycle as a write to 0xC. This keeps the divider restart and the counting separate. The random alarm cases draw unmasked bytes with bit 7 clear, so a compared byte can never look masked by accident.

// File: rtl/tick_alarm_irq_pkg.sv
package tick_alarm_irq_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 4'hC;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 4'hD;

    // enable / rate register layout, MSB first
    typedef struct packed {
        logic       wake_en;   // alarm may interrupt in backup mode
        logic       pfail_en;
        logic       alarm_en;
        logic       tick_en;
        logic [3:0] rate;
    } enable_reg_t;

    // sticky flag layout, MSB first
    typedef struct packed {
        logic alarm;
        logic tick;
        logic pfail;
    } flag_vec_t;

    localparam int FLAG_W = $bits(flag_vec_t);

    // alarm byte i lives at the odd address 2*i+1
    function automatic logic [ADDR_W-1:0] alarm_addr(input int idx);
        alarm_addr = ADDR_W'(2 * idx + 1);
    endfunction

    // a byte whose two top bits are both set is left out of the compare
    function automatic logic byte_is_masked(input logic [DATA_W-1:0] b);
        byte_is_masked = (b[DATA_W-1:DATA_W-2] == 2'b11);
    endfunction

endpackage

// File: rtl/rate_tick_gen.sv
module rate_tick_gen #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              tick_en,
    input  logic [RATE_W-1:0] rate,
    output logic              evt
);
    // largest code (2^RATE_W - 1) needs 2^RATE_W - 2 divider bits
    localparam int DIV_W = ((1 << RATE_W) > 3) ? ((1 << RATE_W) - 2) : 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] sel_mask;

    // low (rate-1) bits all ones marks the last pulse of a period
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            sel_mask[i] = (i < (int'(rate) - 1));
        end
    end

    assign evt = tick_en && (rate != '0) && ((cnt_q & sel_mask) == sel_mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import tick_alarm_irq_pkg::*;
#(
    parameter int N_ALM = 4
) (
    input  logic                         upd_stb,
    input  logic [N_ALM-1:0][DATA_W-1:0] alarm_bytes,
    input  logic [N_ALM-1:0][DATA_W-1:0] time_bytes,
    output logic                         hit
);
    logic [N_ALM-1:0] byte_ok;

    for (genvar g = 0; g < N_ALM; g++) begin : g_cmp
        assign byte_ok[g] = byte_is_masked(alarm_bytes[g]) ||
                            (alarm_bytes[g] == time_bytes[g]);
    end

    assign hit = upd_stb && (&byte_ok);

endmodule

// File: rtl/flag_clr_qual.sv
module flag_clr_qual #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_flags,
    output logic clr
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYC);

    logic [CNT_W-1:0] hold_q;

    // counts consecutive edges spent reading the flags address
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (rd_flags) begin
            if (hold_q != CNT_MAX) begin
                hold_q <= hold_q + 1'b1;
            end
        end else begin
            hold_q <= '0;
        end
    end

    // clear fires once, in the cycle after a qualified read has ended
    assign clr = !rd_flags && (hold_q == CNT_MAX);

endmodule

// File: rtl/tick_alarm_irq.sv
module tick_alarm_irq
    import tick_alarm_irq_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    parameter int RATE_W   = 4,
    parameter int N_ALM    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick32k_en,
    input  logic              upd_stb,
    input  logic [DATA_W-1:0] sec_bcd,
    input  logic [DATA_W-1:0] min_bcd,
    input  logic [DATA_W-1:0] hr_bcd,
    input  logic [DATA_W-1:0] date_bcd,
    input  logic              pwr_fail_evt,
    input  logic              backup_mode,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);
    enable_reg_t en_q;
    flag_vec_t   flags_q;
    flag_vec_t   flag_set;
    logic [N_ALM-1:0][DATA_W-1:0] alm_q;
    logic [N_ALM-1:0][DATA_W-1:0] time_vec;

    logic wr_acc, rd_acc, en_wr, rd_flags, clr_pulse;
    logic tick_evt, alarm_hit;
    logic pend, wake;

    assign wr_acc   = bus_sel && bus_we;
    assign rd_acc   = bus_sel && !bus_we;
    assign en_wr    = wr_acc && (bus_addr == ADDR_ENABLE);
    assign rd_flags = rd_acc && (bus_addr == ADDR_FLAGS);

    // alarm slot order: seconds, minutes, hours, date
    assign time_vec = {date_bcd, hr_bcd, min_bcd, sec_bcd};

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= enable_reg_t'(bus_wdata);
        end
    end

    for (genvar g = 0; g < N_ALM; g++) begin : g_alm
        always_ff @(posedge clk) begin
            if (rst) begin
                alm_q[g] <= '0;
            end else if (wr_acc && (bus_addr == alarm_addr(g))) begin
                alm_q[g] <= bus_wdata;
            end
        end
    end

    // ---------------- event sources ----------------
    rate_tick_gen #(
        .RATE_W (RATE_W)
    ) u_rate (
        .clk     (clk),
        .rst     (rst),
        .restart (en_wr),
        .tick_en (tick32k_en),
        .rate    (en_q.rate[RATE_W-1:0]),
        .evt     (tick_evt)
    );

    alarm_match #(
        .N_ALM (N_ALM)
    ) u_match (
        .upd_stb     (upd_stb),
        .alarm_bytes (alm_q),
        .time_bytes  (time_vec),
        .hit         (alarm_hit)
    );

    flag_clr_qual #(
        .HOLD_CYC (HOLD_CYC)
    ) u_clr (
        .clk      (clk),
        .rst      (rst),
        .rd_flags (rd_flags),
        .clr      (clr_pulse)
    );

    // ---------------- sticky flags ----------------
    always_comb begin
        flag_set       = '0;
        flag_set.alarm = alarm_hit;
        flag_set.tick  = tick_evt;
        flag_set.pfail = pwr_fail_evt;
    end

    // a set arriving with the clear survives it
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (clr_pulse ? flag_vec_t'('0) : flags_q) | flag_set;
        end
    end

    // ---------------- read back ----------------
    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            if (bus_addr == ADDR_ENABLE) begin
                bus_rdata = en_q;
            end else if (bus_addr == ADDR_FLAGS) begin
                bus_rdata = DATA_W'(flags_q);
            end
            for (int i = 0; i < N_ALM; i++) begin
                if (bus_addr == alarm_addr(i)) begin
                    bus_rdata = alm_q[i];
                end
            end
        end
    end

    // ---------------- interrupt ----------------
    assign pend = (flags_q.alarm && en_q.alarm_en) ||
                  (flags_q.tick  && en_q.tick_en)  ||
                  (flags_q.pfail && en_q.pfail_en);
    assign wake = en_q.wake_en && en_q.alarm_en && flags_q.alarm;

    assign irq_n = backup_mode ? !wake : !pend;

endmodule

// File: rtl/tick_alarm_irq_chk.sv
module tick_alarm_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       backup_mode,
    input logic       pwr_fail_evt,
    input logic       upd_stb,
    input logic       irq_n,
    input logic [7:0] en_bits,
    input logic [2:0] flag_bits,
    input logic       clr_pulse
);
    // R2: code 0 never produces a periodic flag
    p_zero_rate_r2: assert property (@(posedge clk) disable iff (rst)
        (en_bits[3:0] == 4'd0 && !flag_bits[1]) |=> !flag_bits[1]);

    // R4: alarm flag only rises on an update strobe
    p_alarm_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (!upd_stb && !flag_bits[2]) |=> !flag_bits[2]);

    // R6: power-fail event is captured on the next edge
    p_pfail_set_r6: assert property (@(posedge clk) disable iff (rst)
        pwr_fail_evt |=> flag_bits[0]);

    // R7: enabled power-fail flag pulls the line outside backup
    p_irq_pfail_r7: assert property (@(posedge clk) disable iff (rst)
        (!backup_mode && flag_bits[0] && en_bits[6]) |-> !irq_n);

    // R8: flags only vanish through a qualified clear
    p_hold_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_bits != 3'b000 && !clr_pulse) |=> flag_bits != 3'b000);

    // R9: event coinciding with a clear keeps its flag
    p_set_beats_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_fail_evt && clr_pulse) |=> flag_bits[0]);

    // R10: without an alarm flag the line is quiet in backup
    p_backup_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (backup_mode && !flag_bits[2]) |-> irq_n);

endmodule

bind tick_alarm_irq tick_alarm_irq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .backup_mode  (backup_mode),
    .pwr_fail_evt (pwr_fail_evt),
    .upd_stb      (upd_stb),
    .irq_n        (irq_n),
    .en_bits      (en_q),
    .flag_bits    (flags_q),
    .clr_pulse    (clr_pulse)
);

// File: tb/tick_alarm_irq_bench.sv
`timescale 1ns/1ps
module tick_alarm_irq_bench;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0, upd = 1'b0, pfail = 1'b0, backup = 1'b0;
    logic [7:0] sec = 8'h0, mins = 8'h0, hrs = 8'h0, date = 8'h0;
    logic       sel = 1'b0, we = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h0;
    logic [7:0] rdata;
    logic       irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    tick_alarm_irq #(.HOLD_CYC(HOLD)) u_tick_alarm_irq (
        .clk(clk), .rst(rst), .tick32k_en(tick_en), .upd_stb(upd),
        .sec_bcd(sec), .min_bcd(mins), .hr_bcd(hrs), .date_bcd(date),
        .pwr_fail_evt(pfail), .backup_mode(backup),
        .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input int hold, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        repeat (hold) @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic peek_flags(output logic [7:0] d);
        bus_read(4'hD, 1, d);
    endtask

    task automatic clear_flags();
        logic [7:0] d;
        bus_read(4'hD, HOLD, d);
        @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic pulse_upd();
        @(negedge clk); upd = 1'b1;
        @(negedge clk); upd = 1'b0;
    endtask

    task automatic pulse_pfail();
        @(negedge clk); pfail = 1'b1;
        @(negedge clk); pfail = 1'b0;
    endtask

    task automatic set_alarm(input logic [31:0] al);
        for (int j = 0; j < 4; j++) bus_write(4'(2 * j + 1), al[8*j +: 8]);
    endtask

    function automatic bit exp_alarm(input logic [31:0] al, input logic [31:0] tm);
        bit ok = 1'b1;
        for (int j = 0; j < 4; j++) begin
            if (al[8*j+7 -: 2] != 2'b11 && al[8*j +: 8] != tm[8*j +: 8]) ok = 1'b0;
        end
        return ok;
    endfunction

    task automatic alarm_case(input string req, input logic [31:0] al, input logic [31:0] tm);
        logic [7:0] d;
        set_alarm(al);
        @(negedge clk);
        {date, hrs, mins, sec} = tm;
        pulse_upd();
        peek_flags(d);
        chk(req, {31'd0, d[2]}, {31'd0, exp_alarm(al, tm)});
        clear_flags();
    endtask

    task automatic period_case(input int n);
        logic [7:0] d;
        int p = 1 << (n - 1);
        bus_write(4'hC, 8'h10 | 8'(n));
        for (int rep = 0; rep < 2; rep++) begin
            if (p > 1) begin
                pulse_tick(p - 1);
                peek_flags(d);
                chk($sformatf("R3 rate %0d before period", n), {31'd0, d[1]}, 32'd0);
            end
            pulse_tick(1);
            peek_flags(d);
            chk($sformatf("R3 rate %0d at period", n), {31'd0, d[1]}, 32'd1);
            #1 chk("R7 periodic irq", {31'd0, irq_n}, 32'd0);
            clear_flags();
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(2718));

        repeat (3) @(negedge clk);
        #1 chk("R1 irq_n in reset", {31'd0, irq_n}, 32'd1);
        rst = 1'b0;

        // R1 reset state
        bus_read(4'hC, 1, d); chk("R1 enable reg", {24'd0, d}, 32'd0);
        bus_read(4'hD, 1, d); chk("R1 flags reg", {24'd0, d}, 32'd0);
        bus_read(4'h1, 1, d); chk("R1 alarm 0x1", {24'd0, d}, 32'd0);
        bus_read(4'h7, 1, d); chk("R1 alarm 0x7", {24'd0, d}, 32'd0);
        pulse_pfail();
        peek_flags(d); chk("R1 flag only after reset", {24'd0, d}, 32'h01);
        #1 chk("R1 irq_n stays high", {31'd0, irq_n}, 32'd1);
        clear_flags();

        // R2 rate code zero
        bus_write(4'hC, 8'h10);
        pulse_tick(40);
        peek_flags(d); chk("R2 no periodic flag", {31'd0, d[1]}, 32'd0);
        #1 chk("R2 irq_n high", {31'd0, irq_n}, 32'd1);

        // R3 directed and random rates
        period_case(1); period_case(2); period_case(3); period_case(5);
        for (int k = 0; k < 4; k++) period_case(1 + int'($urandom % 7));
        bus_write(4'hC, 8'h00);

        // R6 / R7 power fail with enable
        bus_write(4'hC, 8'h40);
        pulse_pfail();
        peek_flags(d); chk("R6 power-fail flag", {24'd0, d}, 32'h01);
        #1 chk("R7 irq on enabled flag", {31'd0, irq_n}, 32'd0);

        // R8 short read keeps flags, qualified read clears
        bus_read(4'hD, HOLD - 1, d);
        chk("R8 short read data", {24'd0, d}, 32'h01);
        @(negedge clk);
        peek_flags(d); chk("R8 short read no clear", {24'd0, d}, 32'h01);
        clear_flags();
        peek_flags(d); chk("R8 long read clears", {24'd0, d}, 32'h00);
        #1 chk("R7 irq released", {31'd0, irq_n}, 32'd1);

        // R9 set coincides with clear
        set_alarm(32'hFFFF_FFFF);
        pulse_upd();
        pulse_pfail();
        bus_read(4'hD, HOLD, d);
        chk("R9 pre-clear flags", {24'd0, d}, 32'h05);
        pfail = 1'b1;
        @(negedge clk); pfail = 1'b0;
        peek_flags(d); chk("R9 set survives clear", {24'd0, d}, 32'h01);
        clear_flags();

        // R4 no strobe, no alarm
        {date, hrs, mins, sec} = 32'h0;
        repeat (6) @(negedge clk);
        peek_flags(d); chk("R4 no flag without strobe", {31'd0, d[2]}, 32'd0);

        // R5 mask patterns
        alarm_case("R5 all masked", 32'hFFFF_FFFF, 32'h1209_4433);
        alarm_case("R5 seconds hit", 32'hFFFF_FF30, 32'h1209_4430);
        alarm_case("R5 seconds miss", 32'hFFFF_FF30, 32'h1209_4431);
        alarm_case("R5 min+sec hit", 32'hFFFF_1530, 32'h1209_1530);
        alarm_case("R5 min+sec miss", 32'hFFFF_1530, 32'h1209_1630);
        alarm_case("R5 daily hit", 32'hFF08_1530, 32'h2808_1530);
        alarm_case("R5 daily miss", 32'hFF08_1530, 32'h2809_1530);
        alarm_case("R5 date miss", 32'h2108_1530, 32'h2208_1530);
        alarm_case("R5 date hit", 32'h2108_1530, 32'h2108_1530);
        alarm_case("R4 PM hour compared", 32'hFF81_FFFF, 32'h0101_0000);

        // R4 random alarm compares
        for (int it = 0; it < 40; it++) begin
            logic [31:0] al, tm;
            for (int j = 0; j < 4; j++) begin
                if ($urandom % 3 == 0) al[8*j +: 8] = {2'b11, 6'($urandom)};
                else                   al[8*j +: 8] = {1'b0, 7'($urandom)};
                tm[8*j +: 8] = ($urandom % 2 == 1) ? al[8*j +: 8] : {1'b0, 7'($urandom)};
            end
            alarm_case("R4 random alarm", al, tm);
        end

        // R10 backup gating
        set_alarm(32'hFFFF_FFFF);
        bus_write(4'hE, 8'h00);
        bus_write(4'hC, 8'hE0);
        @(negedge clk); backup = 1'b1;
        pulse_pfail();
        #1 chk("R10 power-fail quiet in backup", {31'd0, irq_n}, 32'd1);
        pulse_upd();
        #1 chk("R10 alarm wakes in backup", {31'd0, irq_n}, 32'd0);
        clear_flags();
        bus_write(4'hC, 8'h60);
        pulse_upd();
        #1 chk("R10 no wake without enable", {31'd0, irq_n}, 32'd1);
        @(negedge clk); backup = 1'b0;
        #1 chk("R7 alarm irq after backup", {31'd0, irq_n}, 32'd0);
        clear_flags();

        // R11 register layout
        bus_write(4'hC, 8'hA5);
        bus_read(4'hC, 1, d); chk("R11 enable readback", {24'd0, d}, 32'hA5);
        bus_write(4'hD, 8'hFF);
        peek_flags(d); chk("R11 flags write ignored", {24'd0, d}, 32'h00);
        bus_read(4'h0, 1, d); chk("R11 unused address", {24'd0, d}, 32'h00);
        bus_write(4'hC, 8'h00);
        pulse_tick(1);
        pulse_pfail();
        bus_write(4'hC, 8'h01);
        pulse_tick(1);
        peek_flags(d); chk("R11 flag bit positions", {24'd0, d}, 32'h03);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule